// File: doc/BRIEF.md
# Single-Pin Input Debounce Filter with Edge Events

This block cleans up one input pin that has already been brought into the local clock domain. It does not look at the pin on every clock. It samples only when a periodic check strobe arrives, for example once per millisecond. It holds a filtered level and a down-counter.

The filtered level changes only after the raw pin has disagreed with it on a set number of consecutive checks. Any check on which the pin agrees with the filtered level reloads the counter. The number of checks needed is set separately for a rising transition and for a falling one. Each time a new level is accepted, the block can raise a single-cycle event pulse. Whether it does depends on two mode pins: active-low selects which level counts as asserted, and both-edges makes every accepted change produce an event.

An initialize strobe loads the filtered level straight from the pin and re-arms the counter. This is used when the pin is first brought into service. The block has no data stream, so all of its pins are plain control and status signals.

Top module: `dbn_pin_filter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `level_o` is 0 and `event_o` is 0; the counter starts armed with the rising count.
- R2: In the cycle after a cycle with `init_i` high, `level_o` equals the `raw_i` value of that cycle and `event_o` is 0.
- R3: A check on which `raw_i` equals `level_o` reloads the counter. A disagreement that lasts fewer consecutive checks than the required count, followed by an agreeing check, leaves `level_o` unchanged. After such an interruption, the full count is needed again.
- R4: With `level_o` at 0, `level_o` becomes 1 in the cycle after the RISE_CHECKS-th consecutive check with `raw_i` at 1, and not earlier.
- R5: With `level_o` at 1, `level_o` becomes 0 in the cycle after the FALL_CHECKS-th consecutive check with `raw_i` at 0, and not earlier.
- R6: With `act_low_i`=0 and `both_edges_i`=0, an accepted change to 1 gives an event and an accepted change to 0 gives none.
- R7: With `act_low_i`=1 and `both_edges_i`=0, an accepted change to 0 gives an event and an accepted change to 1 gives none.
- R8: With `both_edges_i`=1, every accepted change gives an event, whatever `act_low_i` is.
- R9: `event_o` is high for exactly one clock cycle. That cycle is the one right after the check strobe that commits the change, and it coincides with the cycle in which `level_o` first shows the new value.
- R10: Check strobes that arrive while `init_i` is high are ignored: they neither commit a level nor produce an event.
- R11: `level_o` changes only in the cycle after a check strobe or an initialize strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_i | input | 1 | Periodic check strobe, one cycle wide |
| raw_i | input | 1 | Synchronized raw pin level |
| init_i | input | 1 | Load filtered level from pin and re-arm counter |
| act_low_i | input | 1 | Pin is asserted when low |
| both_edges_i | input | 1 | Report every accepted change |
| level_o | output | 1 | Filtered pin level |
| event_o | output | 1 | One-cycle event on a qualifying accepted change |

## Verification
The assertions assume three things about the inputs. The check strobe is never high on two consecutive cycles. The mode pins are held steady from the committing check until the event appears. `raw_i` is already synchronous to `clk`. The stimulus meets these conditions in the following way. Each check is a single-cycle strobe separated by idle cycles. Mode pins and initialization are changed only between scenarios, while no strobe is pending. The pin level is driven on the falling clock edge.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

  // Action the counter takes on a qualified check
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_RELOAD = 2'd1,
    ACT_COUNT  = 2'd2,
    ACT_COMMIT = 2'd3
  } dbn_act_e;

  // Number of checks needed to leave the given level
  function automatic int unsigned leave_count(input logic lvl,
                                              input int unsigned rise_n,
                                              input int unsigned fall_n);
    return lvl ? fall_n : rise_n;
  endfunction

  function automatic logic event_qualifies(input logic new_lvl,
                                           input logic act_low,
                                           input logic both);
    return both | (act_low ? ~new_lvl : new_lvl);
  endfunction

endpackage

// File: rtl/dbn_count.sv
module dbn_count
  import dbn_pkg::*;
#(
  parameter int unsigned RISE_CHECKS = 2,
  parameter int unsigned FALL_CHECKS = 2,
  parameter int unsigned CW          = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_i,
  input  logic init_i,
  input  logic raw_i,
  input  logic level_i,
  output logic commit_o
);

  localparam int unsigned MAXC = (RISE_CHECKS > FALL_CHECKS) ? RISE_CHECKS : FALL_CHECKS;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          differ;
  dbn_act_e      act;

  assign differ = raw_i ^ level_i;

  always_comb begin
    if (init_i || !chk_i)       act = ACT_HOLD;
    else if (!differ)           act = ACT_RELOAD;
    else if (cnt_q <= CW'(1))   act = ACT_COMMIT;
    else                        act = ACT_COUNT;
  end

  assign commit_o = (act == ACT_COMMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (init_i) begin
      cnt_d = CW'(leave_count(raw_i, RISE_CHECKS, FALL_CHECKS));
    end else begin
      case (act)
        ACT_RELOAD: cnt_d = CW'(leave_count(level_i, RISE_CHECKS, FALL_CHECKS));
        ACT_COMMIT: cnt_d = CW'(leave_count(raw_i, RISE_CHECKS, FALL_CHECKS));
        ACT_COUNT:  cnt_d = cnt_q - CW'(1);
        default:    cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(RISE_CHECKS);
    else        cnt_q <= cnt_d;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && (cnt_q <= CW'(MAXC))) else $error("count out of range"); // R3

  AST_AGREE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_i && !init_i && !differ) |=>
      (cnt_q == CW'(leave_count($past(level_i), RISE_CHECKS, FALL_CHECKS))))
    else $error("agreeing check did not reload"); // R3

endmodule

// File: rtl/dbn_commit.sv
module dbn_commit
  import dbn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic commit_i,
  input  logic raw_i,
  input  logic act_low_i,
  input  logic both_edges_i,
  output logic level_o,
  output logic event_o
);

  logic level_q;
  logic event_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      event_q <= 1'b0;
    end else if (init_i) begin
      level_q <= raw_i;
      event_q <= 1'b0;
    end else if (commit_i) begin
      level_q <= raw_i;
      event_q <= event_qualifies(raw_i, act_low_i, both_edges_i);
    end else begin
      event_q <= 1'b0;
    end
  end

  assign level_o = level_q;
  assign event_o = event_q;

  AST_EVENT_WITH_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    event_q |-> (level_q != $past(level_q))) else $error("event without level change"); // R9

  AST_INIT_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> !event_q) else $error("event after init"); // R2

  AST_EVENT_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    (event_q && !$past(both_edges_i)) |-> (level_q == !$past(act_low_i)))
    else $error("event on wrong edge"); // R6

endmodule

// File: rtl/dbn_pin_filter.sv
module dbn_pin_filter
  import dbn_pkg::*;
#(
  parameter int unsigned RISE_CHECKS = 2,
  parameter int unsigned FALL_CHECKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_i,
  input  logic raw_i,
  input  logic init_i,
  input  logic act_low_i,
  input  logic both_edges_i,
  output logic level_o,
  output logic event_o
);

  localparam int unsigned MAXC = (RISE_CHECKS > FALL_CHECKS) ? RISE_CHECKS : FALL_CHECKS;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic commit;
  logic level;

  dbn_count #(
    .RISE_CHECKS(RISE_CHECKS),
    .FALL_CHECKS(FALL_CHECKS),
    .CW         (CW)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_i    (chk_i),
    .init_i   (init_i),
    .raw_i    (raw_i),
    .level_i  (level),
    .commit_o (commit)
  );

  dbn_commit u_commit (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_i       (init_i),
    .commit_i     (commit),
    .raw_i        (raw_i),
    .act_low_i    (act_low_i),
    .both_edges_i (both_edges_i),
    .level_o      (level),
    .event_o      (event_o)
  );

  assign level_o = level;

  AST_LEVEL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> ($past(chk_i) || $past(init_i)))
    else $error("level moved without strobe"); // R11

  AST_INIT_BLOCKS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_i && init_i) |=> !event_o) else $error("check honoured during init"); // R10

endmodule

// File: tb/sim_dbn_pin_filter.sv
module sim_dbn_pin_filter;

  localparam int unsigned RISE = 3;
  localparam int unsigned FALL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk = 1'b0;
  logic raw = 1'b0;
  logic init = 1'b0;
  logic act_low = 1'b0;
  logic both = 1'b0;
  logic level;
  logic ev;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbn_pin_filter #(.RISE_CHECKS(RISE), .FALL_CHECKS(FALL)) u0 (
    .clk(clk), .rst_n(rst_n), .chk_i(chk), .raw_i(raw), .init_i(init),
    .act_low_i(act_low), .both_edges_i(both), .level_o(level), .event_o(ev)
  );

  task automatic expect_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // one check strobe with the given pin level; samples one cycle later
  task automatic strobe(input logic pin, output logic lv, output logic e);
    @(negedge clk);
    raw = pin;
    chk = 1'b1;
    @(negedge clk);
    chk = 1'b0;
    lv = level;
    e  = ev;
    @(negedge clk);
  endtask

  task automatic do_init(input logic pin);
    @(negedge clk);
    raw  = pin;
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    expect_bit("R1", "level during reset", level, 1'b0);
    expect_bit("R1", "event during reset", ev, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_bit("R1", "level after reset", level, 1'b0);
    expect_bit("R1", "event after reset", ev, 1'b0);
  endtask

  task automatic t_init();
    @(negedge clk);
    raw = 1'b1;
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    expect_bit("R2", "level after init high", level, 1'b1);
    expect_bit("R2", "event after init", ev, 1'b0);
    do_init(1'b0);
    expect_bit("R2", "level after init low", level, 1'b0);
  endtask

  task automatic t_rise_fall_high();
    logic lv, e;
    act_low = 1'b0; both = 1'b0;
    for (int i = 1; i < int'(RISE); i++) begin
      strobe(1'b1, lv, e);
      expect_bit("R4", "level before rise count", lv, 1'b0);
    end
    @(negedge clk); raw = 1'b1; chk = 1'b1;
    @(negedge clk); chk = 1'b0;
    expect_bit("R4", "level at rise commit", level, 1'b1);
    expect_bit("R6", "event on rise active-high", ev, 1'b1);
    @(negedge clk);
    expect_bit("R9", "event drops after one cycle", ev, 1'b0);
    strobe(1'b0, lv, e);
    expect_bit("R5", "level after one low check", lv, 1'b1);
    strobe(1'b0, lv, e);
    expect_bit("R5", "level after fall count", lv, 1'b0);
    expect_bit("R6", "no event on fall active-high", e, 1'b0);
  endtask

  task automatic t_glitch();
    logic lv, e;
    act_low = 1'b0; both = 1'b0;
    strobe(1'b1, lv, e);
    strobe(1'b1, lv, e);
    strobe(1'b0, lv, e);
    expect_bit("R3", "short pulse rejected", lv, 1'b0);
    expect_bit("R3", "no event on short pulse", e, 1'b0);
    strobe(1'b1, lv, e);
    strobe(1'b1, lv, e);
    expect_bit("R3", "count restarted after agree", lv, 1'b0);
    strobe(1'b1, lv, e);
    expect_bit("R3", "commit after full recount", lv, 1'b1);
    expect_bit("R6", "event after recount", e, 1'b1);
  endtask

  task automatic t_active_low();
    logic lv, e;
    act_low = 1'b1; both = 1'b0;
    strobe(1'b0, lv, e);
    strobe(1'b0, lv, e);
    expect_bit("R7", "level fell", lv, 1'b0);
    expect_bit("R7", "event on fall active-low", e, 1'b1);
    for (int i = 0; i < int'(RISE); i++) strobe(1'b1, lv, e);
    expect_bit("R7", "level rose", lv, 1'b1);
    expect_bit("R7", "no event on rise active-low", e, 1'b0);
  endtask

  task automatic t_both();
    logic lv, e;
    act_low = 1'b1; both = 1'b1;
    strobe(1'b0, lv, e);
    strobe(1'b0, lv, e);
    expect_bit("R8", "event on fall both-edges", e, 1'b1);
    for (int i = 0; i < int'(RISE); i++) strobe(1'b1, lv, e);
    expect_bit("R8", "event on rise both-edges", e, 1'b1);
    expect_bit("R8", "level high", lv, 1'b1);
  endtask

  task automatic t_init_blocks();
    logic seen;
    act_low = 1'b0; both = 1'b0;
    do_init(1'b0);
    seen = 1'b0;
    @(negedge clk);
    raw = 1'b1; init = 1'b1;
    for (int i = 0; i < 6; i++) begin
      chk = 1'b1;
      @(negedge clk);
      chk = 1'b0;
      seen = seen | ev;
      @(negedge clk);
      seen = seen | ev;
    end
    init = 1'b0;
    @(negedge clk);
    seen = seen | ev;
    expect_bit("R10", "no event from checks during init", seen, 1'b0);
    expect_bit("R11", "level follows init only", level, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_init();
    t_rise_fall_high();
    t_glitch();
    t_active_low();
    t_both();
    t_init_blocks();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule